// File: doc/BRIEF.md
# Coprocessor Error Port Decoder

This block is an I/O-port slave for the legacy math-coprocessor window, sixteen byte addresses starting at 0xF0. It watches a simple I/O bus made of an address, a write strobe, a read strobe and a flag marking a one-byte access. It owns the coprocessor error interrupt line. An external error pulse raises the line. Any accepted one-byte write inside the window lowers it. The written data value carries no meaning, so the bus has no write-data lane.

Two command ports are decoded. A one-byte write to offset 0 clears the busy latch. A one-byte write to offset 1 resets the coprocessor. Each command produces a single-cycle pulse for the surrounding logic. All other activity in the window is unsupported and sets a sticky diagnostic flag. That covers the opcode-transfer offsets (8, 10, 12) and every other free offset, writes that are not one byte wide, and every read. Reads are never serviced: the cycle after a read strobe, the block signals an unused port and drives the read bus to all ones.

A small state machine registers the class of each access. It stays in `IDLE` while no access hits the window. On a hit it moves to one of five one-cycle states:
- `BUSY_CLR` for a one-byte write at offset 0.
- `COP_RST` for a one-byte write at offset 1.
- `UNSUP_WR` for a one-byte write at any other offset.
- `BAD_SIZE` for a write that is not one byte.
- `READ_TRAP` for any read.

From every state the next hit moves the machine straight to that access's state. No hit returns it to `IDLE`.

Top module: `cop_err_port`

## Requirements
- R1: Out of reset, cop_irq, diag_flag, busy_clr_pulse, cop_reset_pulse and io_rd_unused are 0 and io_rdata is 0.
- R2: A write with io_byte=1 and io_rd=0 to address 0x00F0 raises busy_clr_pulse for exactly the next cycle. cop_irq is 0 from the cycle after that pulse, unless cop_err_in is high in the pulse cycle.
- R3: A one-byte write to address 0x00F1 raises cop_reset_pulse for exactly the next cycle and clears cop_irq in the same way as R2.
- R4: A one-byte write to any window address 0x00F2 to 0x00FF raises no pulse. It sets diag_flag and clears cop_irq, both visible two cycles after the write.
- R5: A write inside the window with io_byte=0 raises no pulse and sets diag_flag two cycles later. It leaves cop_irq unchanged.
- R6: A read inside the window raises io_rd_unused for the next cycle, with io_rdata all ones in that cycle. It sets diag_flag a cycle later and leaves cop_irq unchanged. A cycle with both strobes high counts as a read.
- R7: cop_irq goes to 1 the cycle after cop_err_in is high and holds until a clearing write. When an error pulse and a pending clear meet in the same cycle, the line stays 1.
- R8: diag_flag stays 1 until diag_clr is high. When a pending diagnostic set meets diag_clr in the same cycle, the flag stays 1.
- R9: Accesses outside the window change no output.
- R10: Accesses on consecutive cycles are each handled, and at most one of busy_clr_pulse, cop_reset_pulse and io_rd_unused is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_byte | input | 1 | 1 when the access is one byte wide |
| io_rdata | output | 32 | Read data, all ones on an unused-port response |
| io_rd_unused | output | 1 | Unused-port response to a window read |
| cop_err_in | input | 1 | Coprocessor error pulse |
| diag_clr | input | 1 | Clears the diagnostic flag |
| cop_irq | output | 1 | Coprocessor error interrupt request |
| busy_clr_pulse | output | 1 | One-cycle busy-latch clear command |
| cop_reset_pulse | output | 1 | One-cycle coprocessor reset command |
| diag_flag | output | 1 | Sticky unsupported-access flag |

## Verification
A state machine stuck in or wrongly entering a command state shows at the pins the next cycle. It appears as a missing, doubled or exchanged pulse or unused-port response. A wrong class that only steers the interrupt or diagnostic latch shows one cycle later, as a cop_irq that fails to drop or drops after a bad-size write or read, or as a diag_flag that stays low. The scoreboard compares every output on every cycle against a model of the latches. A decode slip at any of the sixteen offsets, or at the window edges, is therefore caught within two cycles of the offending access.

// File: rtl/cop_port_pkg.sv
`timescale 1ns/1ps
package cop_port_pkg;

    typedef enum logic [2:0] {
        AC_NONE,
        AC_BUSY_CLR,
        AC_COP_RST,
        AC_UNSUP_WR,
        AC_BAD_SIZE,
        AC_READ
    } acc_class_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BUSY_CLR,
        ST_COP_RST,
        ST_UNSUP_WR,
        ST_BAD_SIZE,
        ST_READ_TRAP
    } cop_state_e;

endpackage

// File: rtl/cop_port_classify.sv
`timescale 1ns/1ps
module cop_port_classify
    import cop_port_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int WIN_LOG2 = 4,
    parameter logic [ADDR_W-1:0] BASE = 16'h00F0,
    parameter int CLR_OFF  = 0,
    parameter int RST_OFF  = 1
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic              io_byte,
    output acc_class_e        acc_class
);
    localparam int HI_W = ADDR_W - WIN_LOG2;
    localparam logic [HI_W-1:0]     BASE_HI = BASE[ADDR_W-1:WIN_LOG2];
    localparam logic [WIN_LOG2-1:0] CLR_O   = WIN_LOG2'(CLR_OFF);
    localparam logic [WIN_LOG2-1:0] RST_O   = WIN_LOG2'(RST_OFF);

    logic                hit;
    logic [WIN_LOG2-1:0] offset;

    always_comb begin
        hit       = (io_addr[ADDR_W-1:WIN_LOG2] == BASE_HI);
        offset    = io_addr[WIN_LOG2-1:0];
        acc_class = AC_NONE;
        if (hit) begin
            if (io_rd) begin
                acc_class = AC_READ;
            end else if (io_wr) begin
                if (!io_byte)
                    acc_class = AC_BAD_SIZE;
                else if (offset == CLR_O)
                    acc_class = AC_BUSY_CLR;
                else if (offset == RST_O)
                    acc_class = AC_COP_RST;
                else
                    acc_class = AC_UNSUP_WR;
            end
        end
    end
endmodule

// File: rtl/cop_port_fsm.sv
`timescale 1ns/1ps
module cop_port_fsm
    import cop_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  acc_class_e acc_class,
    output cop_state_e state,
    output logic       busy_clr_pulse,
    output logic       cop_reset_pulse,
    output logic       irq_clr_req,
    output logic       diag_set_req,
    output logic       rd_trap
);
    cop_state_e state_q, state_d;

    always_comb begin
        state_d = ST_IDLE;
        unique case (acc_class)
            AC_NONE:     state_d = ST_IDLE;
            AC_BUSY_CLR: state_d = ST_BUSY_CLR;
            AC_COP_RST:  state_d = ST_COP_RST;
            AC_UNSUP_WR: state_d = ST_UNSUP_WR;
            AC_BAD_SIZE: state_d = ST_BAD_SIZE;
            AC_READ:     state_d = ST_READ_TRAP;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        busy_clr_pulse  = 1'b0;
        cop_reset_pulse = 1'b0;
        irq_clr_req     = 1'b0;
        diag_set_req    = 1'b0;
        rd_trap         = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_BUSY_CLR: begin
                busy_clr_pulse = 1'b1;
                irq_clr_req    = 1'b1;
            end
            ST_COP_RST: begin
                cop_reset_pulse = 1'b1;
                irq_clr_req     = 1'b1;
            end
            ST_UNSUP_WR: begin
                irq_clr_req  = 1'b1;
                diag_set_req = 1'b1;
            end
            ST_BAD_SIZE: diag_set_req = 1'b1;
            ST_READ_TRAP: begin
                rd_trap      = 1'b1;
                diag_set_req = 1'b1;
            end
            default: ;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/cop_sticky_bit.sv
`timescale 1ns/1ps
module cop_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (set_i)
            q <= 1'b1;
        else if (clr_i)
            q <= 1'b0;
    end
endmodule

// File: rtl/cop_err_port.sv
`timescale 1ns/1ps
module cop_err_port
    import cop_port_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int WIN_LOG2 = 4,
    parameter logic [ADDR_W-1:0] BASE = 16'h00F0,
    parameter int CLR_OFF  = 0,
    parameter int RST_OFF  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic              io_byte,
    output logic [DATA_W-1:0] io_rdata,
    output logic              io_rd_unused,
    input  logic              cop_err_in,
    input  logic              diag_clr,
    output logic              cop_irq,
    output logic              busy_clr_pulse,
    output logic              cop_reset_pulse,
    output logic              diag_flag
);
    acc_class_e acc_class;
    cop_state_e fsm_state;
    logic       irq_clr_req;
    logic       diag_set_req;
    logic       rd_trap;

    cop_port_classify #(
        .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .BASE(BASE),
        .CLR_OFF(CLR_OFF), .RST_OFF(RST_OFF)
    ) u_classify (
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_byte(io_byte), .acc_class(acc_class)
    );

    cop_port_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .acc_class(acc_class), .state(fsm_state),
        .busy_clr_pulse(busy_clr_pulse), .cop_reset_pulse(cop_reset_pulse),
        .irq_clr_req(irq_clr_req), .diag_set_req(diag_set_req), .rd_trap(rd_trap)
    );

    cop_sticky_bit u_irq (
        .clk(clk), .rst_n(rst_n), .set_i(cop_err_in), .clr_i(irq_clr_req), .q(cop_irq)
    );

    cop_sticky_bit u_diag (
        .clk(clk), .rst_n(rst_n), .set_i(diag_set_req), .clr_i(diag_clr), .q(diag_flag)
    );

    assign io_rd_unused = rd_trap;
    assign io_rdata     = rd_trap ? {DATA_W{1'b1}} : {DATA_W{1'b0}};
endmodule

// File: rtl/cop_err_port_chk.sv
`timescale 1ns/1ps
module cop_err_port_chk
    import cop_port_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int WIN_LOG2 = 4,
    parameter logic [ADDR_W-1:0] BASE = 16'h00F0,
    parameter int CLR_OFF  = 0,
    parameter int RST_OFF  = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic              io_byte,
    input logic              io_rd_unused,
    input logic              cop_err_in,
    input logic              diag_clr,
    input logic              cop_irq,
    input logic              busy_clr_pulse,
    input logic              cop_reset_pulse,
    input logic              diag_flag,
    input cop_state_e        fsm_state
);
    logic in_win;
    logic byte_wr;
    assign in_win  = (io_addr[ADDR_W-1:WIN_LOG2] == BASE[ADDR_W-1:WIN_LOG2]);
    assign byte_wr = in_win && io_wr && !io_rd && io_byte;

    assert_busy_clr_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_clr_pulse |-> $past(byte_wr && io_addr[WIN_LOG2-1:0] == WIN_LOG2'(CLR_OFF)));

    assert_cop_rst_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cop_reset_pulse |-> $past(byte_wr && io_addr[WIN_LOG2-1:0] == WIN_LOG2'(RST_OFF)));

    assert_unsup_clears_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_UNSUP_WR && !cop_err_in) |=> !cop_irq);

    assert_bad_size_keeps_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_BAD_SIZE && !cop_err_in) |=> $stable(cop_irq));

    assert_read_sets_diag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd_unused |=> diag_flag);

    assert_irq_rise_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cop_irq) |-> $past(cop_err_in));

    assert_diag_fall_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(diag_flag) |-> $past(diag_clr));

    assert_outside_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_wr || io_rd) && !in_win) |=> (fsm_state == ST_IDLE));

    assert_one_response_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy_clr_pulse, cop_reset_pulse, io_rd_unused}));
endmodule

bind cop_err_port cop_err_port_chk #(
    .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .BASE(BASE),
    .CLR_OFF(CLR_OFF), .RST_OFF(RST_OFF)
) u_chk (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_byte(io_byte), .io_rd_unused(io_rd_unused), .cop_err_in(cop_err_in),
    .diag_clr(diag_clr), .cop_irq(cop_irq), .busy_clr_pulse(busy_clr_pulse),
    .cop_reset_pulse(cop_reset_pulse), .diag_flag(diag_flag), .fsm_state(fsm_state)
);

// File: tb/tb_cop_err_port.sv
`timescale 1ns/1ps
module tb_cop_err_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0, io_byte = 1'b0;
    logic [31:0] io_rdata;
    logic        io_rd_unused;
    logic        cop_err_in = 1'b0, diag_clr = 1'b0;
    logic        cop_irq, busy_clr_pulse, cop_reset_pulse, diag_flag;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cop_err_port dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_byte(io_byte), .io_rdata(io_rdata), .io_rd_unused(io_rd_unused),
        .cop_err_in(cop_err_in), .diag_clr(diag_clr), .cop_irq(cop_irq),
        .busy_clr_pulse(busy_clr_pulse), .cop_reset_pulse(cop_reset_pulse),
        .diag_flag(diag_flag)
    );

    typedef struct {
        logic        busy;
        logic        crst;
        logic        unused;
        logic [31:0] rdata;
        logic        irq;
        logic        diag;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    logic irq_m = 0, diag_m = 0, pend_clr = 0, pend_set = 0;

    task automatic step(input logic [15:0] a, input logic w, input logic r,
                        input logic b, input logic err, input logic dclr, input string tag);
        exp_t e;
        logic inwin;
        @(negedge clk);
        io_addr = a; io_wr = w; io_rd = r; io_byte = b;
        cop_err_in = err; diag_clr = dclr;
        irq_m  = err ? 1'b1 : (pend_clr ? 1'b0 : irq_m);
        diag_m = pend_set ? 1'b1 : (dclr ? 1'b0 : diag_m);
        inwin  = (a[15:4] == 12'h00F);
        e.unused = inwin && r;
        e.busy   = inwin && !r && w && b && a[3:0] == 4'h0;
        e.crst   = inwin && !r && w && b && a[3:0] == 4'h1;
        e.rdata  = e.unused ? 32'hFFFF_FFFF : 32'h0;
        e.irq    = irq_m;
        e.diag   = diag_m;
        e.tag    = tag;
        pend_clr = inwin && !r && w && b;
        pend_set = inwin && (r || (w && (!b || a[3:0] > 4'h1)));
        sb_q.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(16'h0000, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                checks++;
                if (busy_clr_pulse !== e.busy || cop_reset_pulse !== e.crst ||
                    io_rd_unused !== e.unused || io_rdata !== e.rdata ||
                    cop_irq !== e.irq || diag_flag !== e.diag) begin
                    failures++;
                    $display("FAIL %s: busy=%b/%b rst=%b/%b unused=%b/%b rdata=%h/%h irq=%b/%b diag=%b/%b (actual/expected)",
                             e.tag, busy_clr_pulse, e.busy, cop_reset_pulse, e.crst,
                             io_rd_unused, e.unused, io_rdata, e.rdata,
                             cop_irq, e.irq, diag_flag, e.diag);
                end
            end
        end
    end

    initial begin : watchdog
        #20000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        checks++;
        if (cop_irq !== 0 || diag_flag !== 0 || busy_clr_pulse !== 0 ||
            cop_reset_pulse !== 0 || io_rd_unused !== 0 || io_rdata !== 0) begin
            failures++;
            $display("FAIL R1: irq=%b diag=%b busy=%b rst=%b unused=%b rdata=%h expected all 0",
                     cop_irq, diag_flag, busy_clr_pulse, cop_reset_pulse, io_rd_unused, io_rdata);
        end
        rst_n = 1'b1;
        idle("R1 idle after reset");
        idle("R1 idle");
        // R7: error raises the line and it holds
        step(16'h0000, 0, 0, 0, 1, 0, "R7 error pulse");
        idle("R7 hold");
        idle("R7 hold");
        // R5: non-byte write keeps irq, sets diag
        step(16'h00F0, 1, 0, 0, 0, 0, "R5 wide write");
        idle("R5 follow");
        idle("R5 diag visible");
        step(16'h0000, 0, 0, 0, 0, 1, "R8 diag clear");
        idle("R8 cleared");
        // R6: read trap
        step(16'h00F7, 0, 1, 1, 0, 0, "R6 read");
        idle("R6 follow");
        idle("R6 diag visible");
        step(16'h0000, 0, 0, 0, 0, 1, "R8 diag clear");
        // R9: outside the window
        step(16'h0092, 1, 0, 1, 0, 0, "R9 write outside");
        step(16'h00EF, 1, 0, 1, 0, 0, "R9 write below window");
        step(16'h0100, 0, 1, 1, 0, 0, "R9 read above window");
        step(16'h01F0, 1, 0, 1, 0, 0, "R9 alias upper bits");
        idle("R9 follow");
        // R2: busy clear
        step(16'h00F0, 1, 0, 1, 0, 0, "R2 busy clear");
        idle("R2 irq drop");
        idle("R2 hold low");
        // R3: coprocessor reset
        step(16'h0000, 0, 0, 0, 1, 0, "R3 error");
        step(16'h00F1, 1, 0, 1, 0, 0, "R3 cop reset");
        idle("R3 irq drop");
        idle("R3 hold low");
        // R4: every other offset
        for (int off = 2; off < 16; off++) begin
            step(16'h0000, 0, 0, 0, 1, 0, "R4 error");
            step(16'h00F0 | 16'(off), 1, 0, 1, 0, 0, "R4 unsupported write");
            idle("R4 follow");
            idle("R4 effect");
            step(16'h0000, 0, 0, 0, 0, 1, "R4 diag clear");
        end
        // R7: error meets a pending clear
        step(16'h00F0, 1, 0, 1, 0, 0, "R7 clear write");
        step(16'h0000, 0, 0, 0, 1, 0, "R7 error with clear");
        idle("R7 stays high");
        // R8: set meets clear
        step(16'h00F3, 0, 1, 1, 0, 0, "R8 read");
        step(16'h0000, 0, 0, 0, 0, 1, "R8 clear with set");
        idle("R8 stays set");
        step(16'h0000, 0, 0, 0, 0, 1, "R8 diag clear");
        // R10: back-to-back accesses
        step(16'h0000, 0, 0, 0, 1, 0, "R10 error");
        step(16'h00F0, 1, 0, 1, 0, 0, "R10 busy clear");
        step(16'h00F1, 1, 0, 1, 0, 0, "R10 cop reset");
        step(16'h00F8, 1, 0, 1, 0, 0, "R10 opcode port");
        step(16'h00FA, 0, 1, 1, 0, 0, "R10 read");
        step(16'h00FC, 1, 0, 0, 0, 0, "R10 wide write");
        idle("R10 follow");
        idle("R10 settle");
        // R6: both strobes counted as read
        step(16'h0000, 0, 0, 0, 1, 1, "R6 error and diag clear");
        step(16'h00F0, 1, 1, 1, 0, 0, "R6 read plus write");
        idle("R6 irq kept");
        idle("R6 settle");
        idle("drain");
        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule